// File: doc/BRIEF.md
# GF(2^9) Reed-Solomon Check-Symbol Encoder

This block produces the ten check symbols that protect one flash page chunk. A chunk is 516 bytes: 512 bytes of user data plus wear-leveling bytes, all covered by the same check symbols. Bytes arrive on a valid/ready input. The block regroups them into 9-bit symbols and feeds each symbol into a systematic polynomial-division register. It works over GF(2^9), using a shortened code of 469 symbols with 459 data symbols and 10 check symbols, which gives a minimum distance of 11.

Every data symbol leaves on the symbol output as soon as it has been formed. When check generation is enabled, the ten check symbols follow straight after the last data symbol. The check symbols are also held as one packed vector. A one-cycle `start` pulse opens a frame and clears all state. `enable` is sampled at `start` and chooses between encoding and pass-through. `done` marks the last symbol of the frame.

Top module: `rs_parity_gen`

## Requirements
- R1: `in_ready` is low after reset and before any `start`. It is high from the cycle after `start` until the 516th byte of the frame is accepted.
- R2: `start` clears the packing state, the division register, the counters and the outputs. The result of a new frame depends only on bytes accepted after that `start`, even when the previous frame was left incomplete.
- R3: Bytes are packed MSB first. Bit 7 of the first byte becomes bit 8 of symbol 0. A frame yields exactly 459 symbols. The last symbol holds the 6 leftover bits in its top positions, followed by 3 zero bits.
- R4: Each data symbol appears unchanged on `out_sym`, with `out_valid` high for one cycle, in packing order. It appears one cycle after the byte or padding step that completes it. `out_valid` is never high for any other reason than a data or check symbol.
- R5: The check symbols are the remainder of D(x)·x^10 divided by g(x). In D(x) the first data symbol is the highest coefficient. The field uses x^9+x^4+1 with alpha = 2, and g(x) is the product of (x + alpha^i) for i = 0..9.
- R6: When enabled, the ten check symbols follow the padded symbol on consecutive cycles, coefficient of x^9 first. A frame therefore outputs 469 symbols.
- R7: `done` is a one-cycle pulse that coincides with the final output symbol of the frame.
- R8: Bits [9k+8:9k] of `parity_vec` hold the remainder coefficient of x^k. The vector is stable from the last data symbol until the next `start`.
- R9: If `enable` is low at `start`, only the 459 data symbols are output and `parity_vec` stays zero.
- R10: The 469-symbol codeword made of the data symbols followed by the check symbols evaluates to zero at alpha^0 through alpha^9.
- R11: Once a frame is complete, `in_ready` stays low. Bytes presented then cause no output and leave `parity_vec` unchanged until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a frame and clears all state |
| enable | input | 1 | Check generation on (1) or pass-through (0), sampled at start |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept a byte |
| out_valid | output | 1 | Output symbol valid |
| out_sym | output | 9 | Data or check symbol |
| parity_vec | output | 90 | Packed check symbols, x^k coefficient at bits [9k+8:9k] |
| done | output | 1 | Final symbol of the frame |

## Verification
All-zero bytes must give an all-zero remainder, which exposes stray feedback or a bad reset. Incrementing bytes and pseudo-random bytes, the latter with idle gaps on the input, drive every packing phase and reveal errors in the generator coefficients or in tap ordering. These results are compared against a long division in the bench that builds its field from log tables, and the syndromes of the observed codeword are also evaluated. An all-ones frame in pass-through mode makes the padded last symbol visible as 0x1F8 and confirms that no check symbols appear. An aborted frame followed by a fresh one shows that `start` wipes out any partial history.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int SYM_W       = 9;
  localparam int NPAR        = 10;
  localparam int CHUNK_BYTES = 516;
  localparam logic [SYM_W:0] FIELD_POLY = 10'h211;  // x^9 + x^4 + 1

  typedef logic [SYM_W-1:0] sym_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PAD, ST_PARITY} enc_state_e;

  // Shift-and-add product in GF(2^SYM_W)
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc ^= sh;
      sh = sh[SYM_W-1] ? ((sh << 1) ^ FIELD_POLY[SYM_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  // Coefficients g[0..NPAR-1] of prod (x + alpha^i); leading coefficient is 1
  function automatic logic [NPAR*SYM_W-1:0] gen_coeffs();
    sym_t g [NPAR+1];
    sym_t root;
    logic [NPAR*SYM_W-1:0] flat;
    for (int k = 0; k <= NPAR; k++) g[k] = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < NPAR; i++) begin
      for (int k = NPAR; k > 0; k--) g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, sym_t'(2));
    end
    flat = '0;
    for (int k = 0; k < NPAR; k++) flat[k*SYM_W +: SYM_W] = g[k];
    return flat;
  endfunction
endpackage

// File: rtl/rs_sym_packer.sv
module rs_sym_packer #(
  parameter int SW = 9,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          byte_fire,
  input  logic          pad_fire,
  input  logic [BW-1:0] byte_in,
  output logic          sym_valid,
  output logic [SW-1:0] sym_out
);
  localparam int AW   = SW - 1;            // leftover bits never reach a full symbol
  localparam int CW   = AW + BW;
  localparam int CNTW = $clog2(SW + BW + 1);

  logic [AW-1:0]    acc_q, acc_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]    merged, kept;
  logic [CNTW-1:0]  total, spill;
  logic [AW+SW-1:0] padw;

  always_comb begin
    merged    = {acc_q, byte_in};
    total     = cnt_q + CNTW'(BW);
    spill     = total - CNTW'(SW);
    kept      = merged & ((CW'(1) << spill) - CW'(1));
    padw      = {{SW{1'b0}}, acc_q} << (CNTW'(SW) - cnt_q);
    sym_valid = 1'b0;
    sym_out   = '0;
    acc_d     = acc_q;
    cnt_d     = cnt_q;
    if (pad_fire) begin
      sym_valid = (cnt_q != '0);
      sym_out   = padw[SW-1:0];
      acc_d     = '0;
      cnt_d     = '0;
    end else if (byte_fire) begin
      if (total >= CNTW'(SW)) begin
        sym_valid = 1'b1;
        sym_out   = SW'(merged >> spill);
        acc_d     = kept[AW-1:0];
        cnt_d     = spill;
      end else begin
        acc_d = merged[AW-1:0];
        cnt_d = total;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rs_lfsr_enc.sv
module rs_lfsr_enc #(
  parameter int             SW  = 9,
  parameter int             NP  = 10,
  parameter logic [NP*SW-1:0] GEN = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic [SW-1:0]    sym_in,
  output logic [NP*SW-1:0] rem_q
);
  logic [SW-1:0]    fb;
  logic [NP*SW-1:0] rem_d;

  assign fb = sym_in ^ rem_q[(NP-1)*SW +: SW];

  for (genvar i = 0; i < NP; i++) begin : g_stage
    logic [SW-1:0] prod;
    assign prod = rs_pkg::gf_mul(fb, GEN[i*SW +: SW]);
    if (i == 0) begin : g_low
      assign rem_d[0 +: SW] = prod;
    end else begin : g_mid
      assign rem_d[i*SW +: SW] = rem_q[(i-1)*SW +: SW] ^ prod;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rem_q <= '0;
    else if (clr)      rem_q <= '0;
    else if (shift_en) rem_q <= rem_d;
  end
endmodule

// File: rtl/rs_parity_gen.sv
module rs_parity_gen #(
  parameter int SYM_BITS = rs_pkg::SYM_W,
  parameter int NUM_PAR  = rs_pkg::NPAR,
  parameter int CHUNK    = rs_pkg::CHUNK_BYTES,
  parameter int BYTE_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        enable,
  input  logic                        in_valid,
  input  logic [BYTE_W-1:0]           in_data,
  output logic                        in_ready,
  output logic                        out_valid,
  output logic [SYM_BITS-1:0]         out_sym,
  output logic [NUM_PAR*SYM_BITS-1:0] parity_vec,
  output logic                        done
);
  import rs_pkg::*;

  localparam int NDATA = (CHUNK*BYTE_W + SYM_BITS - 1) / SYM_BITS;
  localparam int BCW   = $clog2(CHUNK + 1);
  localparam int SCW   = $clog2(NDATA + 1);
  localparam int PCW   = $clog2(NUM_PAR + 1);
  localparam logic [NUM_PAR*SYM_BITS-1:0] GEN = gen_coeffs();

  enc_state_e          state_q;
  logic                par_en_q;
  logic [BCW-1:0]      byte_cnt_q;
  logic [SCW-1:0]      dsym_cnt_q;
  logic [PCW-1:0]      pidx_q;

  // named events
  logic                byte_fire, pad_fire, pk_valid, last_data, par_phase, last_par;
  logic [SYM_BITS-1:0] pk_sym, par_sel;

  assign in_ready  = (state_q == ST_LOAD);
  assign byte_fire = in_valid & in_ready;
  assign pad_fire  = (state_q == ST_PAD);
  assign last_data = pk_valid && (dsym_cnt_q == SCW'(NDATA-1));
  assign par_phase = (state_q == ST_PARITY);
  assign last_par  = par_phase && (pidx_q == PCW'(NUM_PAR-1));

  rs_sym_packer #(.SW(SYM_BITS), .BW(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .byte_fire(byte_fire), .pad_fire(pad_fire), .byte_in(in_data),
    .sym_valid(pk_valid), .sym_out(pk_sym)
  );

  rs_lfsr_enc #(.SW(SYM_BITS), .NP(NUM_PAR), .GEN(GEN)) u_enc (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .shift_en(pk_valid & par_en_q), .sym_in(pk_sym), .rem_q(parity_vec)
  );

  // highest-order remainder coefficient first
  always_comb begin
    par_sel = '0;
    for (int k = 0; k < NUM_PAR; k++)
      if (pidx_q == PCW'(NUM_PAR-1-k)) par_sel = parity_vec[k*SYM_BITS +: SYM_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      par_en_q   <= 1'b0;
      byte_cnt_q <= '0;
      dsym_cnt_q <= '0;
      pidx_q     <= '0;
      out_valid  <= 1'b0;
      out_sym    <= '0;
      done       <= 1'b0;
    end else if (start) begin
      state_q    <= ST_LOAD;
      par_en_q   <= enable;
      byte_cnt_q <= '0;
      dsym_cnt_q <= '0;
      pidx_q     <= '0;
      out_valid  <= 1'b0;
      out_sym    <= '0;
      done       <= 1'b0;
    end else begin
      out_valid <= pk_valid | par_phase;
      out_sym   <= par_phase ? par_sel : pk_sym;
      done      <= (last_data & ~par_en_q) | last_par;
      if (byte_fire) byte_cnt_q <= byte_cnt_q + BCW'(1);
      if (pk_valid)  dsym_cnt_q <= dsym_cnt_q + SCW'(1);
      unique case (state_q)
        ST_LOAD:
          if (byte_fire && byte_cnt_q == BCW'(CHUNK-1))
            state_q <= !last_data ? ST_PAD : (par_en_q ? ST_PARITY : ST_IDLE);
        ST_PAD:
          state_q <= par_en_q ? ST_PARITY : ST_IDLE;
        ST_PARITY: begin
          pidx_q <= pidx_q + PCW'(1);
          if (last_par) state_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rs_parity_gen_chk.sv
module rs_parity_gen_chk #(
  parameter int NP   = 10,
  parameter int SW   = 9,
  parameter int NSYM = 469
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_ready,
  input logic             out_valid,
  input logic             done,
  input logic             par_phase,
  input logic             par_en,
  input logic [NP*SW-1:0] parity_vec
);
  localparam int OCW = $clog2(NSYM + 2);
  logic [OCW-1:0] sym_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  sym_seen <= '0;
    else if (start)                              sym_seen <= '0;
    else if (out_valid && sym_seen != '1)        sym_seen <= sym_seen + OCW'(1);
  end

  AST_DONE_WITH_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);                                                   // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                       // R7
  AST_CLOSED_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);                                                   // R11
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (parity_vec == '0 && !out_valid && !done));                  // R2
  AST_BYPASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en |-> parity_vec == '0);                                         // R9
  AST_PARITY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (par_phase && !start) |=> $stable(parity_vec));                        // R8
  AST_SYM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sym_seen <= OCW'(NSYM));                                               // R6
endmodule

bind rs_parity_gen rs_parity_gen_chk #(
  .NP(NUM_PAR), .SW(SYM_BITS), .NSYM(NDATA + NUM_PAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready),
  .out_valid(out_valid), .done(done), .par_phase(par_phase),
  .par_en(par_en_q), .parity_vec(parity_vec)
);

// File: tb/rs_parity_gen_tb_top.sv
module rs_parity_gen_tb_top;
  import rs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NB = CHUNK_BYTES;
  localparam int NS = (NB*8 + SYM_W - 1) / SYM_W;
  localparam int NC = NS + NPAR;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, enable = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, done;
  logic [SYM_W-1:0] out_sym;
  logic [NPAR*SYM_W-1:0] parity_vec;

  rs_parity_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_sym(out_sym), .parity_vec(parity_vec), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int exp_tab [512];
  int log_tab [512];
  int genp [NPAR+1];
  int bytes_a [NB];
  int syms [NC];
  int obs [NC];
  int obs_n = 0;
  int exp_sym_q [$];
  bit exp_last_q [$];
  bit exp_par_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_tab[(log_tab[a] + log_tab[b]) % 511];
  endfunction

  task automatic build_field();
    int v = 1;
    for (int i = 0; i < 511; i++) begin
      exp_tab[i] = v;
      log_tab[v] = i;
      v = v << 1;
      if ((v & 512) != 0) v = v ^ 'h211;
    end
    for (int k = 0; k <= NPAR; k++) genp[k] = 0;
    genp[0] = 1;
    for (int i = 0; i < NPAR; i++) begin
      for (int k = NPAR; k > 0; k--) genp[k] = genp[k-1] ^ fmul(genp[k], exp_tab[i]);
      genp[0] = fmul(genp[0], exp_tab[i]);
    end
  endtask

  // bytes, MSB-first symbols, and long-division remainder
  task automatic build_frame(input int pattern, input int seed);
    int s = seed;
    int work [NC];
    for (int i = 0; i < NB; i++) begin
      case (pattern)
        0: bytes_a[i] = 0;
        1: bytes_a[i] = i & 255;
        2: begin s = s * 1103515245 + 12345; bytes_a[i] = (s >>> 16) & 255; end
        default: bytes_a[i] = 255;
      endcase
    end
    for (int k = 0; k < NS; k++) begin
      int v = 0;
      for (int b = 0; b < SYM_W; b++) begin
        int pos = k*SYM_W + b;
        int bitv = (pos < NB*8) ? ((bytes_a[pos/8] >> (7 - pos%8)) & 1) : 0;
        v = (v << 1) | bitv;
      end
      syms[k] = v;
    end
    for (int k = 0; k < NC; k++) work[k] = (k < NS) ? syms[k] : 0;
    for (int i = 0; i < NS; i++) begin
      int c = work[i];
      if (c != 0)
        for (int j = 1; j <= NPAR; j++) work[i+j] ^= fmul(c, genp[NPAR-j]);
    end
    for (int k = NS; k < NC; k++) syms[k] = work[k];
  endtask

  task automatic push_expected(input int count, input bit en);
    for (int k = 0; k < count; k++) begin
      exp_sym_q.push_back(syms[k]);
      exp_last_q.push_back(!en && k == NS-1);
      exp_par_q.push_back(1'b0);
    end
    if (en)
      for (int k = 0; k < NPAR; k++) begin
        exp_sym_q.push_back(syms[NS+k]);
        exp_last_q.push_back(k == NPAR-1);
        exp_par_q.push_back(1'b1);
      end
  endtask

  // monitor / scoreboard
  int m_sym;
  bit m_last, m_par;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (exp_sym_q.size() == 0) begin
          check(1'b0, "R4", "symbol with nothing expected", out_sym, 0);
        end else begin
          m_sym  = exp_sym_q.pop_front();
          m_last = exp_last_q.pop_front();
          m_par  = exp_par_q.pop_front();
          check(int'(out_sym) == m_sym, m_par ? "R5/R6" : "R3/R4", "symbol", out_sym, m_sym);
          check(done == m_last, "R7", "done flag", done, m_last);
          if (obs_n < NC) begin
            obs[obs_n] = int'(out_sym);
            obs_n++;
          end
        end
      end else if (done) begin
        check(1'b0, "R7", "done without symbol", 1, 0);
      end
    end
  end

  task automatic open_frame(input bit en);
    @(negedge clk);
    start = 1'b1;
    enable = en;
    @(negedge clk);
    start = 1'b0;
    obs_n = 0;
    check(in_ready == 1'b1, "R1", "ready while frame open", in_ready, 1);
  endtask

  task automatic send_bytes(input int count, input int gap);
    for (int i = 0; i < count; i++) begin
      bit rdy;
      in_valid = 1'b1;
      in_data  = 8'(bytes_a[i]);
      forever begin
        rdy = in_ready;
        @(negedge clk);
        if (rdy) break;
      end
      in_valid = 1'b0;
      if (gap > 0 && (i % 3) == 2) @(negedge clk);
    end
  endtask

  task automatic drain();
    while (exp_sym_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_vec(input bit en, input string req);
    for (int k = 0; k < NPAR; k++) begin
      int e = en ? syms[NS + NPAR - 1 - k] : 0;
      int a = int'(parity_vec[k*SYM_W +: SYM_W]);
      check(a == e, req, "parity_vec symbol", a, e);
    end
  endtask

  task automatic run_frame(input int pattern, input int seed, input bit en, input int gap);
    build_frame(pattern, seed);
    push_expected(NS, en);
    open_frame(en);
    send_bytes(NB, gap);
    drain();
    check(obs_n == (en ? NC : NS), en ? "R6" : "R9", "symbols per frame", obs_n, en ? NC : NS);
    check_vec(en, en ? "R8" : "R9");
    if (en)
      for (int j = 0; j < NPAR; j++) begin
        int s = 0;
        for (int k = 0; k < NC; k++) s = fmul(s, exp_tab[j]) ^ obs[k];
        check(s == 0, "R10", "syndrome", s, 0);
      end
    // R11: bytes after completion are refused and change nothing
    in_valid = 1'b1;
    in_data  = 8'hA5;
    repeat (4) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R11", "ready after frame", in_ready, 0);
    end
    in_valid = 1'b0;
    check_vec(en, "R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    build_field();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "reset ready", in_ready, 0);
    check(out_valid == 1'b0, "R4", "reset valid", out_valid, 0);
    check(done == 1'b0, "R7", "reset done", done, 0);
    check(parity_vec == '0, "R8", "reset parity_vec", 0, 0);
    in_valid = 1'b1;
    in_data = 8'h3C;
    repeat (3) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R1", "ready before start", in_ready, 0);
    end
    in_valid = 1'b0;

    run_frame(0, 1, 1'b1, 0);          // all zero
    run_frame(1, 1, 1'b1, 0);          // incrementing
    run_frame(2, 7, 1'b1, 1);          // pseudo-random with gaps
    run_frame(3, 1, 1'b0, 0);          // all ones, pass-through
    check(obs[NS-1] == 'h1F8, "R3", "padded last symbol", obs[NS-1], 'h1F8);

    // R2: abort a partial frame, then restart
    build_frame(2, 99);
    push_expected((100*8)/SYM_W, 1'b0);
    open_frame(1'b1);
    send_bytes(100, 0);
    repeat (3) @(negedge clk);
    check(exp_sym_q.size() == 0, "R2", "partial frame symbols", exp_sym_q.size(), 0);
    run_frame(2, 12345, 1'b1, 0);
    check(int'(parity_vec[(NPAR-1)*SYM_W +: SYM_W]) == syms[NS], "R2",
          "restart top check symbol", parity_vec[(NPAR-1)*SYM_W +: SYM_W], syms[NS]);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule